// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral Timer

This block decides when a half-duplex Ethernet transmitter is allowed to begin a frame. Whenever a transmission ends, or a backoff wait finishes, the block requires a full interframe gap before it grants again. The gap is measured in bit times, and every counter advances only on a one-cycle bit-time enable. The same logic therefore runs at 10 and 100 Mb/s.

The gap has two parts:
- **Guard window.** Counting begins at the first bit time in which carrier sense is seen low. If carrier is sampled high anywhere in this window, the wait starts over.
- **Committed window.** After the guard window the block no longer looks at carrier. The grant arrives on schedule even if carrier has come back, and the resulting collision is accepted as the price.

The grant stays up for as long as the transmitter requests. It drops when the transmitter acknowledges a frame start, and it stays down until the next end-of-transmission pulse has been followed by a complete new gap.

A second, independent part watches the receive activity line. It raises a one-cycle flag when a new receive frame begins after an idle gap that is too short. Downstream logic uses that flag to decide whether to discard the frame.

Top module: `ipg_defer_timer`

## Requirements
- R1: After synchronous reset the block owes no gap. `tx_grant` equals `tx_req`, and `rx_short_gap` is 0.
- R2: `tx_grant` is high only while `tx_req` is high and the gap has been met. Dropping `tx_req` drops `tx_grant` in the same cycle.
- R3: After `tx_end` is pulsed, bit times in which `carrier` is high do not count toward the gap. The gap is met on the GAP_BITS-th bit time (default 96), counted from the first bit time in which `carrier` is low. `tx_grant` is visible in the clock cycle after that bit time.
- R4: If `carrier` is high in any counted position 1..GUARD_BITS (default 60), the count returns to zero, and it restarts at the next bit time in which `carrier` is low.
- R5: `carrier` in positions GUARD_BITS+1..GAP_BITS is ignored, and the gap is still met at position GAP_BITS.
- R6: `carrier` and `rx_active` are sampled only in cycles where `bit_en` is 1. Their values in other cycles have no effect.
- R7: `tx_start` while `tx_grant` is high drops the grant. It stays low for any number of bit times until `tx_end` is pulsed and a new gap completes. `tx_start` while `tx_grant` is low has no effect.
- R8: `tx_end` in any state restarts the gap from the carrier-wait phase, and it wins over a `tx_start` in the same cycle.
- R9: A receive frame is detected when `rx_active` is sampled 1 after being sampled 0. If fewer than RX_MIN_BITS (default 28) samples of 0 lay between that frame and the previous one, `rx_short_gap` is 1 for exactly one cycle, in the cycle after the starting sample. A gap of RX_MIN_BITS or more never raises the flag.
- R10: The first receive frame after reset never raises `rx_short_gap`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle pulse marking a bit time |
| carrier | input | 1 | Carrier sense |
| tx_end | input | 1 | One-cycle pulse: end of transmission or end of backoff |
| tx_req | input | 1 | Transmitter has a frame waiting |
| tx_start | input | 1 | Transmitter acknowledges that a frame is starting |
| rx_active | input | 1 | Receive frame in progress |
| tx_grant | output | 1 | Transmission may begin |
| rx_short_gap | output | 1 | One-cycle flag: the frame just started followed too short a gap |

## Verification
The hardest condition to reach from the ports is carrier arriving exactly at the last guard position or the first committed position. Only one bit-time sample separates a restarted wait from a forced grant. The stimulus sweeps a single carrier-high sample over every position 1..96 of the gap, varies the spacing between `bit_en` pulses, and drives carrier high in every cycle without `bit_en`. For each position the bench derives the grant bit time arithmetically. A second sweep walks the receive idle gap across 1..40 samples, so both 27 and 28 are covered.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

  // Deferral phases of the transmit side.
  typedef enum logic [2:0] {
    DF_READY = 3'd0,  // gap met, grant follows tx_req
    DF_WAIT  = 3'd1,  // waiting for carrier to drop
    DF_OPEN  = 3'd2,  // counting, carrier restarts the wait
    DF_LOCK  = 3'd3,  // counting, carrier ignored
    DF_BUSY  = 3'd4   // frame acknowledged, waiting for end pulse
  } defer_state_t;

endpackage

// File: rtl/ipg_bit_counter.sv
module ipg_bit_counter #(
  parameter int MAXV = 96
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         inc,
  output logic [$clog2(MAXV+1)-1:0]    cnt
);
  localparam int CW = $clog2(MAXV + 1);
  localparam logic [CW-1:0] MAX_V = CW'(MAXV);

  // Saturating bit-time counter; clear has priority over increment.
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && cnt != MAX_V)
      cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= MAX_V);

endmodule

// File: rtl/ipg_tx_defer.sv
module ipg_tx_defer
  import ipg_pkg::*;
#(
  parameter int GAP_BITS   = 96,
  parameter int GUARD_BITS = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic carrier,
  input  logic restart,
  input  logic tx_req,
  input  logic tx_start,
  output logic gap_met
);
  localparam int CW = $clog2(GAP_BITS + 1);
  localparam logic [CW-1:0] GAP_V   = CW'(GAP_BITS);
  localparam logic [CW-1:0] GUARD_V = CW'(GUARD_BITS);

  defer_state_t st, st_n;
  logic [CW-1:0] cnt, cnt_nx;
  logic          clr_c, inc_c;

  ipg_bit_counter #(.MAXV(GAP_BITS)) u_gap_cnt (
    .clk (clk),
    .rst (rst),
    .clr (clr_c),
    .inc (inc_c),
    .cnt (cnt)
  );

  assign cnt_nx = cnt + 1'b1;

  always_comb begin
    st_n  = st;
    clr_c = 1'b0;
    inc_c = 1'b0;
    if (restart) begin
      st_n  = DF_WAIT;
      clr_c = 1'b1;
    end else begin
      case (st)
        DF_WAIT, DF_OPEN: begin
          if (bit_en) begin
            if (carrier) begin
              st_n  = DF_WAIT;
              clr_c = 1'b1;
            end else begin
              inc_c = 1'b1;
              if (cnt_nx == GAP_V)       st_n = DF_READY;
              else if (cnt_nx >= GUARD_V) st_n = DF_LOCK;
              else                        st_n = DF_OPEN;
            end
          end
        end
        DF_LOCK: begin
          if (bit_en) begin
            inc_c = 1'b1;
            if (cnt_nx == GAP_V) st_n = DF_READY;
          end
        end
        DF_READY: begin
          if (tx_start && tx_req) begin
            st_n  = DF_BUSY;
            clr_c = 1'b1;
          end
        end
        DF_BUSY: st_n = DF_BUSY;
        default: st_n = DF_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= DF_READY;
    else     st <= st_n;
  end

  assign gap_met = (st == DF_READY);

  p_guard_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (st == DF_OPEN && bit_en && carrier && !restart)
      |=> (st == DF_WAIT && cnt == '0));

  p_late_carrier_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (st == DF_LOCK && bit_en && carrier && !restart) |=> (st != DF_WAIT));

  p_grant_after_full_gap_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(gap_met) |-> ($past(cnt) == GAP_V - 1'b1 && $past(bit_en)));

  p_busy_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (st == DF_BUSY && !restart) |=> !gap_met);

  p_end_restarts_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (st == DF_WAIT && cnt == '0));

endmodule

// File: rtl/ipg_rx_gap_check.sv
module ipg_rx_gap_check #(
  parameter int RX_MIN_BITS = 28
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_active,
  output logic short_gap
);
  localparam int RW = $clog2(RX_MIN_BITS + 1);
  localparam logic [RW-1:0] MIN_V = RW'(RX_MIN_BITS);

  logic          prev_act;   // last sampled rx_active
  logic          seen_frame; // a frame has been seen since reset
  logic [RW-1:0] idle_cnt;
  logic          clr_c, inc_c, short_c;

  assign clr_c   = bit_en && rx_active;
  assign inc_c   = bit_en && !rx_active && seen_frame;
  assign short_c = bit_en && rx_active && !prev_act && seen_frame && (idle_cnt < MIN_V);

  ipg_bit_counter #(.MAXV(RX_MIN_BITS)) u_idle_cnt (
    .clk (clk),
    .rst (rst),
    .clr (clr_c),
    .inc (inc_c),
    .cnt (idle_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_act   <= 1'b0;
      seen_frame <= 1'b0;
      short_gap  <= 1'b0;
    end else begin
      short_gap <= short_c;
      if (bit_en) begin
        prev_act <= rx_active;
        if (rx_active) seen_frame <= 1'b1;
      end
    end
  end

  p_flag_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    short_gap |=> !short_gap);

  p_flag_on_sample_r9: assert property (@(posedge clk) disable iff (rst)
    short_gap |-> ($past(bit_en) && $past(rx_active)));

  p_no_flag_first_r10: assert property (@(posedge clk) disable iff (rst)
    !seen_frame |=> !short_gap);

endmodule

// File: rtl/ipg_defer_timer.sv
module ipg_defer_timer #(
  parameter int GAP_BITS    = 96,
  parameter int GUARD_BITS  = 60,
  parameter int RX_MIN_BITS = 28
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic carrier,
  input  logic tx_end,
  input  logic tx_req,
  input  logic tx_start,
  input  logic rx_active,
  output logic tx_grant,
  output logic rx_short_gap
);
  logic gap_met;

  ipg_tx_defer #(
    .GAP_BITS   (GAP_BITS),
    .GUARD_BITS (GUARD_BITS)
  ) u_tx_defer (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .carrier  (carrier),
    .restart  (tx_end),
    .tx_req   (tx_req),
    .tx_start (tx_start),
    .gap_met  (gap_met)
  );

  ipg_rx_gap_check #(
    .RX_MIN_BITS (RX_MIN_BITS)
  ) u_rx_gap (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .rx_active (rx_active),
    .short_gap (rx_short_gap)
  );

  assign tx_grant = gap_met && tx_req;

  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> tx_req);

  initial begin
    assert (GUARD_BITS >= 1 && GUARD_BITS < GAP_BITS && RX_MIN_BITS >= 1);
  end

endmodule

// File: tb/ipg_defer_timer_bench.sv
module ipg_defer_timer_bench;
  localparam int GAP   = 96;
  localparam int GUARD = 60;
  localparam int RXMIN = 28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, carrier = 1'b0, tx_end = 1'b0;
  logic tx_req = 1'b1, tx_start = 1'b0, rx_active = 1'b0;
  logic tx_grant, rx_short_gap;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ipg_defer_timer #(.GAP_BITS(GAP), .GUARD_BITS(GUARD), .RX_MIN_BITS(RXMIN)) u_ipg_defer_timer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .carrier(carrier), .tx_end(tx_end),
    .tx_req(tx_req), .tx_start(tx_start), .rx_active(rx_active),
    .tx_grant(tx_grant), .rx_short_gap(rx_short_gap)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One bit time; in the following idle cycles the inputs carry noise (R6).
  task automatic step(input logic c, input logic r, input int idle);
    @(negedge clk);
    bit_en = 1'b1; carrier = c; rx_active = r;
    @(negedge clk);
    bit_en = 1'b0; carrier = 1'b1; rx_active = ~r;
    for (int k = 0; k < idle; k++) @(negedge clk);
  endtask

  task automatic end_pulse(input logic with_start);
    @(negedge clk);
    tx_end = 1'b1; tx_start = with_start;
    @(negedge clk);
    tx_end = 1'b0; tx_start = 1'b0;
  endtask

  task automatic start_pulse();
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  // After an end pulse: pre_hi carrier-high bit times, then counted bit
  // times with carrier high only at position p (0 = never).
  task automatic run_gap(input int pre_hi, input int p, input int idle, input string tag);
    int tgt;
    for (int i = 0; i < pre_hi; i++) step(1'b1, 1'b0, idle);
    tgt = (p >= 1 && p <= GUARD) ? p + GAP : GAP;
    for (int n = 1; n <= tgt; n++) begin
      step(n == p, 1'b0, idle);
      if (n == tgt - 1) chk(tag, tx_grant, 1'b0);
      if (n == tgt)     chk(tag, tx_grant, 1'b1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 grant after reset", tx_grant, 1'b1);
    chk("R1 flag after reset", rx_short_gap, 1'b0);
    tx_req = 1'b0; #1;
    chk("R2 grant without req", tx_grant, 1'b0);
    tx_req = 1'b1; #1;
    chk("R2 grant with req", tx_grant, 1'b1);

    // R3 / R7: plain gap, with an ignored start request mid-gap.
    end_pulse(1'b0);
    for (int n = 1; n <= GAP; n++) begin
      step(1'b0, 1'b0, 0);
      if (n == 50) begin
        start_pulse();
        chk("R7 start while low ignored", tx_grant, 1'b0);
      end
      if (n == GAP - 1) chk("R3 before gap", tx_grant, 1'b0);
      if (n == GAP)     chk("R3 gap met", tx_grant, 1'b1);
    end

    // R3: carrier still high after the end pulse.
    end_pulse(1'b0);
    run_gap(5, 0, 1, "R3 carrier wait");

    // R4 / R5 / R6 sweep of one carrier sample over every position.
    for (int p = 1; p <= GAP; p++) begin
      end_pulse(1'b0);
      run_gap(0, p, p % 3, (p <= GUARD) ? "R4 guard restart" : "R5 late carrier ignored");
    end

    // R7: acknowledged start holds the grant low.
    start_pulse();
    chk("R7 grant drops on start", tx_grant, 1'b0);
    for (int i = 0; i < 150; i++) step(1'b0, 1'b0, 0);
    chk("R7 grant stays low", tx_grant, 1'b0);
    end_pulse(1'b0);
    run_gap(0, 0, 0, "R7 new gap after end");

    // R8: end wins over start; end mid-gap restarts the count.
    end_pulse(1'b1);
    chk("R8 end wins", tx_grant, 1'b0);
    for (int n = 1; n <= 80; n++) step(1'b0, 1'b0, 0);
    end_pulse(1'b0);
    run_gap(0, 0, 0, "R8 mid-gap restart");

    // Receive side.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0);
    step(1'b0, 1'b1, 0);
    chk("R10 first frame", rx_short_gap, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 0);
    for (int g = 1; g <= 40; g++) begin
      for (int i = 0; i < g; i++) step(1'b0, 1'b0, g % 2);
      step(1'b0, 1'b1, 0);
      chk("R9 short gap flag", rx_short_gap, (g < RXMIN));
      step(1'b0, 1'b1, 0);
      chk("R9 flag one cycle", rx_short_gap, 1'b0);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule